// File: doc/BRIEF.md
# Domain Freeze Filter

This block holds the isolation state for every domain behind a PCIe host bridge. Each of 256 domains has two freeze flags: one guarding the memory-mapped path driven by the processor, and one guarding the DMA path driven by devices. An error report for a domain raises both flags in one step. Software then lowers each flag on its own, so that, for example, register access can be restored for diagnosis while DMA stays blocked.

Every transaction reaches the block already carrying its domain number, a kind (load, store or message-signalled interrupt) and a direction. If the relevant flag is clear, the block forwards the transaction one cycle later without change. If the flag is set, the block discards stores, completes loads locally with all-ones data, and suppresses interrupts. Each of these outcomes has its own one-cycle indication. A query port reads both flags of any domain combinationally.

Top module: `domain_freeze_filter`

## Requirements
- R1: After reset every flag of every domain reads 0, and all registered outputs (`fwdValid`, `fakeLdValid`, `dropped`, `msiBlocked`, and the data and field outputs) are 0.
- R2: An `errValid` cycle for domain d sets both the MMIO flag and the DMA flag of d. Both read 1 on the query port in the cycle after that clock edge. Other domains are unaffected.
- R3: A `clrValid` cycle clears the MMIO flag of `clrDomain` when `clrMmio` is 1 and its DMA flag when `clrDma` is 1. A flag whose clear bit is 0 keeps its value.
- R4: When an error and a clear name the same domain in the same cycle, both flags of that domain end up set.
- R5: A store (`txnKind` = 2'b01) whose selected flag is set is not forwarded. `dropped` is 1 for exactly the cycle after it is presented.
- R6: A load (`txnKind` = 2'b00) whose selected flag is set is not forwarded. `fakeLdValid` is 1 in the next cycle, with `fakeLdData` all ones.
- R7: An interrupt (`txnKind` = 2'b10) is always checked against the DMA flag. If that flag is set, the interrupt is not forwarded and `msiBlocked` is 1 in the next cycle.
- R8: For loads and stores, `txnInbound` = 0 (processor to device) selects the MMIO flag and `txnInbound` = 1 (device to host) selects the DMA flag.
- R9: A transaction whose selected flag is clear, and any transaction of reserved kind 2'b11, appears in the next cycle on `fwdValid`, with kind, domain, direction and data unchanged.
- R10: Every transaction takes effect on the flag state as it stood before the clock edge on which it is presented. In any cycle at most one of `fwdValid`, `fakeLdValid`, `dropped` and `msiBlocked` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | Freeze request strobe |
| errDomain | input | 8 | Domain to freeze |
| clrValid | input | 1 | Software clear strobe |
| clrDomain | input | 8 | Domain to clear |
| clrMmio | input | 1 | Clear the MMIO flag |
| clrDma | input | 1 | Clear the DMA flag |
| txnValid | input | 1 | Transaction present |
| txnKind | input | 2 | 00 load, 01 store, 10 interrupt, 11 reserved |
| txnInbound | input | 1 | 1 = device-to-host, 0 = processor-to-device |
| txnDomain | input | 8 | Domain tag of the transaction |
| txnData | input | 64 | Address/data payload |
| qryDomain | input | 8 | Domain whose flags are read |
| qryMmio | output | 1 | MMIO flag of qryDomain |
| qryDma | output | 1 | DMA flag of qryDomain |
| fwdValid | output | 1 | Transaction forwarded |
| fwdKind | output | 2 | Forwarded kind |
| fwdInbound | output | 1 | Forwarded direction |
| fwdDomain | output | 8 | Forwarded domain |
| fwdData | output | 64 | Forwarded payload |
| fakeLdValid | output | 1 | Local load completion |
| fakeLdData | output | 64 | All-ones load data |
| dropped | output | 1 | Store discarded |
| msiBlocked | output | 1 | Interrupt suppressed |

## Verification
A flag stuck at a wrong value does not show until a transaction of the matching path reaches that domain. The query port reveals it one cycle after the update that went wrong. Because the reference model is compared on every clock, a wrong flag is caught at the first transaction or query that touches its domain. The test therefore drives the same domain through both directions and all kinds after each partial clear. A swapped flag selection turns into a load that is forwarded when it should be faked, or the reverse, on the cycle after the transaction.

// File: rtl/fz_pkg.sv
package fz_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD  = 2'b00,
    KIND_STORE = 2'b01,
    KIND_MSI   = 2'b10,
    KIND_RSVD  = 2'b11
  } txn_kind_e;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic pass;
    logic fakeLoad;
    logic dropStore;
    logic blockMsi;
  } fz_strobe_t;
endpackage

// File: rtl/fz_state_table.sv
module fz_state_table
  import fz_pkg::*;
#(
  parameter int DOMAINS = 256,
  parameter int DOM_W   = $clog2(DOMAINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               errValid,
  input  logic [DOM_W-1:0]   errDomain,
  input  logic               clrValid,
  input  logic [DOM_W-1:0]   clrDomain,
  input  logic               clrMmio,
  input  logic               clrDma,
  input  logic               txnValid,
  input  logic [1:0]         txnKind,
  input  logic               txnInbound,
  input  logic [DOM_W-1:0]   txnDomain,
  input  logic [DOM_W-1:0]   qryDomain,
  output logic               qryMmio,
  output logic               qryDma,
  output logic [DOMAINS-1:0] mmioFlags,
  output logic [DOMAINS-1:0] dmaFlags,
  output fz_strobe_t         strobe
);
  for (genvar i = 0; i < DOMAINS; i++) begin : g_entry
    logic hitErr, hitClrM, hitClrD;
    assign hitErr  = errValid && (errDomain == DOM_W'(i));
    assign hitClrM = clrValid && clrMmio && (clrDomain == DOM_W'(i));
    assign hitClrD = clrValid && clrDma && (clrDomain == DOM_W'(i));
    // a set in the same cycle beats a clear
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mmioFlags[i] <= 1'b0;
        dmaFlags[i]  <= 1'b0;
      end else begin
        mmioFlags[i] <= hitErr | (mmioFlags[i] & ~hitClrM);
        dmaFlags[i]  <= hitErr | (dmaFlags[i] & ~hitClrD);
      end
    end
  end

  assign qryMmio = mmioFlags[qryDomain];
  assign qryDma  = dmaFlags[qryDomain];

  txn_kind_e kind;
  logic      useDma;
  logic      frozen;
  assign kind   = txn_kind_e'(txnKind);
  assign useDma = (kind == KIND_MSI) || txnInbound;
  assign frozen = useDma ? dmaFlags[txnDomain] : mmioFlags[txnDomain];

  always_comb begin
    strobe = '0;
    if (txnValid) begin
      unique case (kind)
        KIND_LOAD:  if (frozen) strobe.fakeLoad  = 1'b1; else strobe.pass = 1'b1;
        KIND_STORE: if (frozen) strobe.dropStore = 1'b1; else strobe.pass = 1'b1;
        KIND_MSI:   if (frozen) strobe.blockMsi  = 1'b1; else strobe.pass = 1'b1;
        default:    strobe.pass = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fz_txn_path.sv
module fz_txn_path
  import fz_pkg::*;
#(
  parameter int DOM_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fz_strobe_t        strobe,
  input  logic [1:0]        txnKind,
  input  logic              txnInbound,
  input  logic [DOM_W-1:0]  txnDomain,
  input  logic [DATA_W-1:0] txnData,
  output logic              fwdValid,
  output logic [1:0]        fwdKind,
  output logic              fwdInbound,
  output logic [DOM_W-1:0]  fwdDomain,
  output logic [DATA_W-1:0] fwdData,
  output logic              fakeLdValid,
  output logic [DATA_W-1:0] fakeLdData,
  output logic              dropped,
  output logic              msiBlocked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwdValid    <= 1'b0;
      fwdKind     <= '0;
      fwdInbound  <= 1'b0;
      fwdDomain   <= '0;
      fwdData     <= '0;
      fakeLdValid <= 1'b0;
      fakeLdData  <= '0;
      dropped     <= 1'b0;
      msiBlocked  <= 1'b0;
    end else begin
      fwdValid    <= strobe.pass;
      fwdKind     <= strobe.pass ? txnKind : '0;
      fwdInbound  <= strobe.pass & txnInbound;
      fwdDomain   <= strobe.pass ? txnDomain : '0;
      fwdData     <= strobe.pass ? txnData : '0;
      fakeLdValid <= strobe.fakeLoad;
      fakeLdData  <= strobe.fakeLoad ? '1 : '0;
      dropped     <= strobe.dropStore;
      msiBlocked  <= strobe.blockMsi;
    end
  end
endmodule

// File: rtl/domain_freeze_filter.sv
module domain_freeze_filter
  import fz_pkg::*;
#(
  parameter int DOMAINS = 256,
  parameter int DOM_W   = $clog2(DOMAINS),
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              errValid,
  input  logic [DOM_W-1:0]  errDomain,
  input  logic              clrValid,
  input  logic [DOM_W-1:0]  clrDomain,
  input  logic              clrMmio,
  input  logic              clrDma,
  input  logic              txnValid,
  input  logic [1:0]        txnKind,
  input  logic              txnInbound,
  input  logic [DOM_W-1:0]  txnDomain,
  input  logic [DATA_W-1:0] txnData,
  input  logic [DOM_W-1:0]  qryDomain,
  output logic              qryMmio,
  output logic              qryDma,
  output logic              fwdValid,
  output logic [1:0]        fwdKind,
  output logic              fwdInbound,
  output logic [DOM_W-1:0]  fwdDomain,
  output logic [DATA_W-1:0] fwdData,
  output logic              fakeLdValid,
  output logic [DATA_W-1:0] fakeLdData,
  output logic              dropped,
  output logic              msiBlocked
);
  logic [DOMAINS-1:0] mmioFlags;
  logic [DOMAINS-1:0] dmaFlags;
  fz_strobe_t         strobe;

  fz_state_table #(.DOMAINS(DOMAINS), .DOM_W(DOM_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .errValid(errValid), .errDomain(errDomain),
    .clrValid(clrValid), .clrDomain(clrDomain), .clrMmio(clrMmio), .clrDma(clrDma),
    .txnValid(txnValid), .txnKind(txnKind), .txnInbound(txnInbound), .txnDomain(txnDomain),
    .qryDomain(qryDomain), .qryMmio(qryMmio), .qryDma(qryDma),
    .mmioFlags(mmioFlags), .dmaFlags(dmaFlags), .strobe(strobe)
  );

  fz_txn_path #(.DOM_W(DOM_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .txnKind(txnKind), .txnInbound(txnInbound), .txnDomain(txnDomain), .txnData(txnData),
    .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdInbound(fwdInbound),
    .fwdDomain(fwdDomain), .fwdData(fwdData),
    .fakeLdValid(fakeLdValid), .fakeLdData(fakeLdData),
    .dropped(dropped), .msiBlocked(msiBlocked)
  );
endmodule

// File: rtl/fz_checker.sv
module fz_checker #(
  parameter int DOMAINS = 256,
  parameter int DOM_W   = 8,
  parameter int DATA_W  = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               errValid,
  input logic [DOM_W-1:0]   errDomain,
  input logic               clrValid,
  input logic [DOM_W-1:0]   clrDomain,
  input logic               clrMmio,
  input logic               txnValid,
  input logic [1:0]         txnKind,
  input logic               txnInbound,
  input logic [DOM_W-1:0]   txnDomain,
  input logic [DOMAINS-1:0] mmioFlags,
  input logic [DOMAINS-1:0] dmaFlags,
  input logic               fwdValid,
  input logic               fakeLdValid,
  input logic [DATA_W-1:0]  fakeLdData,
  input logic               dropped,
  input logic               msiBlocked
);
  // R2
  err_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errValid |=> (mmioFlags[$past(errDomain)] && dmaFlags[$past(errDomain)]));

  // R3
  mmio_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clrValid && clrMmio && !(errValid && errDomain == clrDomain))
      |=> !mmioFlags[$past(clrDomain)]);

  // R4
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (errValid && clrValid && errDomain == clrDomain)
      |=> dmaFlags[$past(clrDomain)]);

  // R5
  store_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txnValid && txnKind == 2'b01 && !txnInbound && mmioFlags[txnDomain])
      |=> (dropped && !fwdValid));

  // R6
  fake_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fakeLdValid |-> (fakeLdData == {DATA_W{1'b1}}));

  // R7
  msi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txnValid && txnKind == 2'b10 && dmaFlags[txnDomain]) |=> msiBlocked);

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwdValid, fakeLdValid, dropped, msiBlocked}));
endmodule

bind domain_freeze_filter fz_checker #(.DOMAINS(DOMAINS), .DOM_W(DOM_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .errValid(errValid), .errDomain(errDomain),
  .clrValid(clrValid), .clrDomain(clrDomain), .clrMmio(clrMmio),
  .txnValid(txnValid), .txnKind(txnKind), .txnInbound(txnInbound), .txnDomain(txnDomain),
  .mmioFlags(mmioFlags), .dmaFlags(dmaFlags),
  .fwdValid(fwdValid), .fakeLdValid(fakeLdValid), .fakeLdData(fakeLdData),
  .dropped(dropped), .msiBlocked(msiBlocked)
);

// File: tb/tb_domain_freeze_filter.sv
`timescale 1ns/1ps
module tb_domain_freeze_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        errValid = 0, clrValid = 0, clrMmio = 0, clrDma = 0, txnValid = 0, txnInbound = 0;
  logic [7:0]  errDomain = 0, clrDomain = 0, txnDomain = 0, qryDomain = 0;
  logic [1:0]  txnKind = 0;
  logic [63:0] txnData = 0;
  logic        qryMmio, qryDma, fwdValid, fwdInbound, fakeLdValid, dropped, msiBlocked;
  logic [1:0]  fwdKind;
  logic [7:0]  fwdDomain;
  logic [63:0] fwdData, fakeLdData;

  int checks = 0;
  int fails  = 0;
  bit mm [256];
  bit dm [256];

  always #5 clk = ~clk;

  domain_freeze_filter dut (
    .clk(clk), .rst_n(rst_n),
    .errValid(errValid), .errDomain(errDomain),
    .clrValid(clrValid), .clrDomain(clrDomain), .clrMmio(clrMmio), .clrDma(clrDma),
    .txnValid(txnValid), .txnKind(txnKind), .txnInbound(txnInbound),
    .txnDomain(txnDomain), .txnData(txnData),
    .qryDomain(qryDomain), .qryMmio(qryMmio), .qryDma(qryDma),
    .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdInbound(fwdInbound),
    .fwdDomain(fwdDomain), .fwdData(fwdData),
    .fakeLdValid(fakeLdValid), .fakeLdData(fakeLdData),
    .dropped(dropped), .msiBlocked(msiBlocked)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    errValid = 0; clrValid = 0; clrMmio = 0; clrDma = 0; txnValid = 0;
  endtask

  task automatic txn(input logic [1:0] k, input logic inb, input logic [7:0] d, input logic [63:0] v);
    txnValid = 1; txnKind = k; txnInbound = inb; txnDomain = d; txnData = v;
  endtask

  // one clock: predict from model, advance, compare at the next falling edge
  task automatic step(input string tag);
    bit fz, eFwd, eFake, eDrop, eMsi;
    eFwd = 0; eFake = 0; eDrop = 0; eMsi = 0;
    fz = (txnKind == 2'b10 || txnInbound) ? dm[txnDomain] : mm[txnDomain];
    if (txnValid) begin
      if (txnKind == 2'b11 || !fz) eFwd = 1;
      else if (txnKind == 2'b00) eFake = 1;
      else if (txnKind == 2'b01) eDrop = 1;
      else eMsi = 1;
    end
    if (clrValid) begin
      if (clrMmio) mm[clrDomain] = 0;
      if (clrDma)  dm[clrDomain] = 0;
    end
    if (errValid) begin
      mm[errDomain] = 1;
      dm[errDomain] = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "fwdValid", 64'(fwdValid), 64'(eFwd));
    chk(tag, "fwdKind", 64'(fwdKind), eFwd ? 64'(txnKind) : 64'd0);
    chk(tag, "fwdInbound", 64'(fwdInbound), eFwd ? 64'(txnInbound) : 64'd0);
    chk(tag, "fwdDomain", 64'(fwdDomain), eFwd ? 64'(txnDomain) : 64'd0);
    chk(tag, "fwdData", fwdData, eFwd ? txnData : 64'd0);
    chk(tag, "fakeLdValid", 64'(fakeLdValid), 64'(eFake));
    chk(tag, "fakeLdData", fakeLdData, eFake ? {64{1'b1}} : 64'd0);
    chk(tag, "dropped", 64'(dropped), 64'(eDrop));
    chk(tag, "msiBlocked", 64'(msiBlocked), 64'(eMsi));
    chk(tag, "qryMmio", 64'(qryMmio), 64'(mm[qryDomain]));
    chk(tag, "qryDma", 64'(qryDma), 64'(dm[qryDomain]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    foreach (mm[i]) begin mm[i] = 0; dm[i] = 0; end
    chk("R1", "fwdValid", 64'(fwdValid), 64'd0);
    chk("R1", "fakeLdData", fakeLdData, 64'd0);
    for (int d = 0; d < 256; d += 51) begin
      qryDomain = 8'(d); #1;
      chk("R1", "qryMmio", 64'(qryMmio), 64'd0);
      chk("R1", "qryDma", 64'(qryDma), 64'd0);
    end
    // R9: clean traffic of every kind and direction
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 2; b++) begin
        idle(); txn(2'(k), 1'(b), 8'(7 + k), 64'h1234_0000 + 64'(k * 2 + b)); step("R9");
      end
    // R2: freeze domain 5
    idle(); errValid = 1; errDomain = 8'd5; qryDomain = 8'd5; step("R2");
    idle(); qryDomain = 8'd6; step("R2");
    qryDomain = 8'd5;
    // R5: stores both directions dropped
    idle(); txn(2'b01, 0, 8'd5, 64'hAAAA); step("R5");
    idle(); txn(2'b01, 1, 8'd5, 64'hBBBB); step("R5");
    // R6: load faked
    idle(); txn(2'b00, 0, 8'd5, 64'hCCCC); step("R6");
    // R7: interrupt blocked
    idle(); txn(2'b10, 1, 8'd5, 64'h55); step("R7");
    // R9: reserved kind still forwarded, neighbour unaffected
    idle(); txn(2'b11, 0, 8'd5, 64'hD); step("R9");
    idle(); txn(2'b00, 0, 8'd4, 64'hE); step("R9");
    // R3: clear only MMIO
    idle(); clrValid = 1; clrDomain = 8'd5; clrMmio = 1; step("R3");
    // R8: outbound load passes, inbound load faked, interrupt still blocked
    idle(); txn(2'b00, 0, 8'd5, 64'h11); step("R8");
    idle(); txn(2'b00, 1, 8'd5, 64'h22); step("R8");
    idle(); txn(2'b10, 0, 8'd5, 64'h33); step("R7");
    // R3: clear DMA; everything passes
    idle(); clrValid = 1; clrDomain = 8'd5; clrDma = 1; step("R3");
    idle(); txn(2'b10, 1, 8'd5, 64'h44); step("R3");
    // R4: set and clear collide on domain 255
    idle(); qryDomain = 8'd255;
    errValid = 1; errDomain = 8'd255; clrValid = 1; clrDomain = 8'd255; clrMmio = 1; clrDma = 1;
    step("R4");
    // R10: transaction on the freezing edge uses the old state
    idle(); qryDomain = 8'd0; errValid = 1; errDomain = 8'd0; txn(2'b01, 0, 8'd0, 64'h66); step("R10");
    idle(); txn(2'b01, 0, 8'd0, 64'h67); step("R5");
    idle(); clrValid = 1; clrDomain = 8'd0; clrMmio = 1; clrDma = 1; step("R3");
    // R10: random mix against the model
    for (int n = 0; n < 600; n++) begin
      idle();
      errValid = ($urandom_range(0, 7) == 0); errDomain = 8'($urandom_range(0, 7));
      clrValid = ($urandom_range(0, 3) == 0); clrDomain = 8'($urandom_range(0, 7));
      clrMmio = 1'($urandom); clrDma = 1'($urandom);
      txnValid = 1'($urandom); txnKind = 2'($urandom); txnInbound = 1'($urandom);
      txnDomain = 8'($urandom_range(0, 7)); txnData = {32'($urandom), 32'($urandom)};
      qryDomain = 8'($urandom_range(0, 7));
      step("R10");
    end
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule